// File: doc/BRIEF.md
# Frame-Synced UART Transmit Framer

This block turns bytes into 8-N-1 asynchronous serial characters by sending each one as a fixed 11-bit word on a bit clock that runs at the baud rate. The first bit of the word is an idle one. A start zero follows, then the eight data bits with the least significant bit first, and last a stop one. Words do not start on their own. A frame sync launches each word, and frame syncs are 13 bit clocks apart. The word fills the first 11 bit slots of the frame, and the line stays high in the last two.

Bytes go into an 8-entry FIFO through a single-cycle write port. Bytes may be written while the block is disabled and are held until it is enabled. When enable is low, the bit clock and frame timing stop, the line idles high and the FIFO is not read. Status outputs report that the FIFO is full, that no byte is waiting, that a frame sync found nothing to send (this flag stays set), and that a character is still in flight.

Top module: `fsync_uart_tx`

## Requirements
- R1: After reset, txd_o is 1, fifo_full_o is 0, hold_empty_o is 1, underflow_o is 0 and tx_busy_o is 0.
- R2: One bit lasts 2*(div_i+1) clock cycles, where div_i = f_clk/(2*baud) - 1.
- R3: Each word on the line is a 1, then a start 0, then data bits 0 to 7 in that order, then a stop 1.
- R4: The starts of back-to-back words are exactly 13 bit periods apart. The line is high in the two bit slots that follow each stop bit.
- R5: The FIFO holds 8 bytes. fifo_full_o is 1 when it holds 8 bytes. A write made while it is full is discarded and never sent.
- R6: hold_empty_o is 1 whenever the FIFO holds no byte, including while the last word is still being shifted out with tx_busy_o at 1.
- R7: While en_i is 0, txd_o is 1 from the next cycle on and no byte leaves the FIFO. Writes are still accepted.
- R8: A frame sync while enabled with an empty FIFO sets underflow_o and sends no word. underflow_o stays at 1 until reset.
- R9: tx_busy_o is 1 while the FIFO holds a byte or a word is being sent. It falls at the end of the last stop bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Transmit enable |
| div_i | input | DIV_W | Bit clock divider, half bit period minus one |
| wr_valid_i | input | 1 | Byte write strobe |
| wr_data_i | input | 8 | Byte to send |
| txd_o | output | 1 | Serial line, idles high |
| fifo_full_o | output | 1 | FIFO holds 8 bytes |
| hold_empty_o | output | 1 | No byte waiting to be sent |
| underflow_o | output | 1 | Sticky flag: a frame sync found the FIFO empty |
| tx_busy_o | output | 1 | A byte is waiting or a word is on the line |

## Verification
The bench uses the default parameters: an 8-entry FIFO, 13-slot frames and an 8-bit divider. At run time it sets div_i between 0 and 3, so a bit lasts 2 to 8 cycles and a full FIFO drains in a few hundred cycles. This keeps several things within easy reach: the exact 13-bit frame spacing, the discarded ninth write, the sticky underflow after the FIFO drains, and an enable drop in the middle of a word, all checked under more than one bit period.

// File: rtl/fsu_pkg.sv
package fsu_pkg;
  localparam int unsigned DATA_W = 8;
  localparam int unsigned WORD_W = DATA_W + 3;

  // idle one, start zero, data LSB first, stop one
  function automatic logic [WORD_W-1:0] make_word(input logic [DATA_W-1:0] d);
    return {1'b1, d, 1'b0, 1'b1};
  endfunction
endpackage

// File: rtl/fsu_bit_clk.sv
module fsu_bit_clk #(
  parameter int unsigned DIV_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);
  logic [DIV_W-1:0] half_q;
  logic             phase_q;
  logic             half_end;

  assign half_end = (half_q == div_i);
  assign tick_o   = en_i && half_end && phase_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      half_q  <= '0;
      phase_q <= 1'b0;
    end else if (!en_i) begin
      half_q  <= '0;
      phase_q <= 1'b0;
    end else if (half_end) begin
      half_q  <= '0;
      phase_q <= ~phase_q;
    end else begin
      half_q  <= half_q + 1'b1;
    end
  end
endmodule

// File: rtl/fsu_fifo.sv
module fsu_fifo #(
  parameter int unsigned WIDTH = 8,
  parameter int unsigned DEPTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  logic [WIDTH-1:0] data_i,
  input  logic             pop_i,
  output logic [WIDTH-1:0] data_o,
  output logic             full_o,
  output logic             empty_o
);
  localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CW = $clog2(DEPTH + 1);

  logic [WIDTH-1:0] mem_q [DEPTH];
  logic [AW-1:0]    wp_q, rp_q;
  logic [CW-1:0]    cnt_q;
  logic             do_push, do_pop;

  assign full_o  = (cnt_q == CW'(DEPTH));
  assign empty_o = (cnt_q == '0);
  assign do_push = push_i && !full_o;
  assign do_pop  = pop_i && !empty_o;
  assign data_o  = mem_q[rp_q];

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i) begin
    if (do_push) mem_q[wp_q] <= data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (do_push) wp_q <= nxt(wp_q);
      if (do_pop)  rp_q <= nxt(rp_q);
      case ({do_push, do_pop})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end
endmodule

// File: rtl/fsu_framer.sv
module fsu_framer
  import fsu_pkg::*;
#(
  parameter int unsigned FS_DIV = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              tick_i,
  input  logic              fifo_empty_i,
  input  logic [DATA_W-1:0] fifo_data_i,
  output logic              pop_o,
  output logic              txd_o,
  output logic              active_o,
  output logic              underflow_o
);
  localparam int unsigned SLOT_W = $clog2(FS_DIV + 1);
  localparam int unsigned LEFT_W = $clog2(WORD_W + 1);

  logic [WORD_W-1:0] sh_q;
  logic [LEFT_W-1:0] left_q;
  logic [SLOT_W-1:0] slot_q;
  logic              uf_q;
  logic              fsync;

  // frame sync is the tick that closes the last slot; disabled state parks there
  assign fsync       = en_i && tick_i && (slot_q == SLOT_W'(FS_DIV));
  assign pop_o       = fsync && !fifo_empty_i;
  assign txd_o       = sh_q[0];
  assign active_o    = (left_q != '0);
  assign underflow_o = uf_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q   <= '1;
      left_q <= '0;
      slot_q <= SLOT_W'(FS_DIV);
      uf_q   <= 1'b0;
    end else if (!en_i) begin
      sh_q   <= '1;
      left_q <= '0;
      slot_q <= SLOT_W'(FS_DIV);
    end else if (tick_i) begin
      if (fsync) begin
        slot_q <= '0;
        if (!fifo_empty_i) begin
          sh_q   <= make_word(fifo_data_i);
          left_q <= LEFT_W'(WORD_W);
        end else begin
          sh_q   <= '1;
          left_q <= '0;
          uf_q   <= 1'b1;
        end
      end else begin
        slot_q <= slot_q + 1'b1;
        sh_q   <= {1'b1, sh_q[WORD_W-1:1]};
        if (left_q != '0) left_q <= left_q - 1'b1;
      end
    end
  end
endmodule

// File: rtl/fsync_uart_tx.sv
module fsync_uart_tx
  import fsu_pkg::*;
#(
  parameter int unsigned DIV_W      = 8,
  parameter int unsigned FIFO_DEPTH = 8,
  parameter int unsigned FS_DIV     = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic [DIV_W-1:0]  div_i,
  input  logic              wr_valid_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic              txd_o,
  output logic              fifo_full_o,
  output logic              hold_empty_o,
  output logic              underflow_o,
  output logic              tx_busy_o
);
  logic              tick;
  logic              pop;
  logic              empty;
  logic              active;
  logic [DATA_W-1:0] head;

  fsu_bit_clk #(.DIV_W(DIV_W)) u_bclk (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .en_i  (en_i),
    .div_i (div_i),
    .tick_o(tick)
  );

  fsu_fifo #(.WIDTH(DATA_W), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .push_i (wr_valid_i),
    .data_i (wr_data_i),
    .pop_i  (pop),
    .data_o (head),
    .full_o (fifo_full_o),
    .empty_o(empty)
  );

  fsu_framer #(.FS_DIV(FS_DIV)) u_frm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .en_i        (en_i),
    .tick_i      (tick),
    .fifo_empty_i(empty),
    .fifo_data_i (head),
    .pop_o       (pop),
    .txd_o       (txd_o),
    .active_o    (active),
    .underflow_o (underflow_o)
  );

  assign hold_empty_o = empty;
  assign tx_busy_o    = active || !empty;
endmodule

// File: rtl/fsync_uart_tx_chk.sv
module fsync_uart_tx_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic en_i,
  input logic wr_valid_i,
  input logic txd_o,
  input logic fifo_full_o,
  input logic hold_empty_o,
  input logic underflow_o,
  input logic tx_busy_o
);
  assert_idle_when_off_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> txd_o);

  assert_underflow_sticky_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    underflow_o |=> underflow_o);

  assert_full_not_empty_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fifo_full_o |-> !hold_empty_o);

  assert_full_write_dropped_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fifo_full_o && wr_valid_i && !en_i) |=> fifo_full_o);

  assert_idle_line_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tx_busy_o |-> (txd_o && hold_empty_o));

  assert_no_underflow_off_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i && !underflow_o) |=> !underflow_o);
endmodule

bind fsync_uart_tx fsync_uart_tx_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .en_i        (en_i),
  .wr_valid_i  (wr_valid_i),
  .txd_o       (txd_o),
  .fifo_full_o (fifo_full_o),
  .hold_empty_o(hold_empty_o),
  .underflow_o (underflow_o),
  .tx_busy_o   (tx_busy_o)
);

// File: tb/test_fsync_uart_tx.sv
module test_fsync_uart_tx;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       en = 1'b0;
  logic [7:0] div = '0;
  logic       wr_valid = 1'b0;
  logic [7:0] wr_data = '0;
  logic       txd, full, hempty, uflow, busy;

  int n_chk = 0;
  int n_bad = 0;
  longint cyc = 0;
  longint last_fall = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  fsync_uart_tx i_fsync_uart_tx (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .div_i(div),
    .wr_valid_i(wr_valid), .wr_data_i(wr_data),
    .txd_o(txd), .fifo_full_o(full), .hold_empty_o(hempty),
    .underflow_o(uflow), .tx_busy_o(busy)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int bitper(input logic [7:0] d);
    return 2 * (int'(d) + 1);
  endfunction

  task automatic do_reset();
    en = 1'b0; wr_valid = 1'b0;
    @(negedge clk); rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic put(input logic [7:0] b);
    @(negedge clk); wr_valid = 1'b1; wr_data = b;
    @(negedge clk); wr_valid = 1'b0;
  endtask

  // wait for a start bit, then sample every bit at its middle
  task automatic rx_byte(input logic [7:0] exp, input bit gap, input bit last, input int p);
    bit prev = txd;
    bit found = 1'b0;
    logic [7:0] got;
    for (int t = 0; t < 20 * p + 40; t++) begin
      @(negedge clk);
      if (prev && !txd) begin found = 1'b1; break; end
      prev = txd;
    end
    chk(found, "R3 start edge", found, 1);
    if (!found) return;
    if (gap) chk(cyc - last_fall == 13 * p, "R4 frame spacing", cyc - last_fall, 13 * p);
    last_fall = cyc;
    chk(hempty == last, "R6 hold_empty at word start", hempty, last);
    chk(busy == 1'b1, "R9 busy during word", busy, 1);
    repeat (p / 2) @(negedge clk);
    chk(txd == 1'b0, "R3 start bit", txd, 0);
    for (int i = 0; i < 8; i++) begin
      repeat (p) @(negedge clk);
      got[i] = txd;
    end
    chk(got == exp, "R3 R2 data byte", got, exp);
    repeat (p) @(negedge clk);
    chk(txd == 1'b1, "R3 stop bit", txd, 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] q [$];
    int p;
    bit hi;
    int rnd;
    rnd = $urandom(32'h5eed_1234);

    do_reset();
    chk(txd == 1'b1, "R1 txd", txd, 1);
    chk(full == 1'b0, "R1 full", full, 0);
    chk(hempty == 1'b1, "R1 hold_empty", hempty, 1);
    chk(uflow == 1'b0, "R1 underflow", uflow, 0);
    chk(busy == 1'b0, "R1 busy", busy, 0);

    // directed: fill while disabled, ninth write dropped
    div = 8'd1; p = bitper(div);
    q.delete();
    for (int i = 0; i < 8; i++) begin
      q.push_back(8'(8'h31 * (i + 1) ^ 8'hA5));
      put(q[i]);
      chk(full == (i == 7), "R5 full flag", full, i == 7);
    end
    put(8'h00);
    chk(full == 1'b1, "R5 full after dropped write", full, 1);
    hi = 1'b1;
    repeat (40) begin @(negedge clk); hi &= txd; end
    chk(hi, "R7 line idle while disabled", hi, 1);
    chk(hempty == 1'b0 && busy == 1'b1, "R7 writes held while disabled", {hempty, busy}, 2'b01);
    @(negedge clk); en = 1'b1;
    for (int i = 0; i < 8; i++) rx_byte(q[i], i != 0, i == 7, p);
    // stop sample is p/2 into the stop bit; it ends p/2 later
    @(negedge clk);
    chk(busy == 1'b1, "R9 busy inside stop bit", busy, 1);
    repeat (p) @(negedge clk);
    chk(busy == 1'b0, "R9 busy after stop bit", busy, 0);
    chk(uflow == 1'b0, "R8 no underflow yet", uflow, 0);
    hi = 1'b1;
    repeat (3 * p) begin @(negedge clk); hi &= txd; end
    chk(hi, "R4 idle slots high", hi, 1);
    chk(uflow == 1'b1, "R8 underflow on empty sync", uflow, 1);
    hi = 1'b1;
    repeat (14 * p) begin @(negedge clk); hi &= txd; end
    chk(hi, "R5 dropped byte never sent", hi, 1);
    @(negedge clk); en = 1'b0;
    repeat (3) @(negedge clk);
    chk(uflow == 1'b1, "R8 underflow sticky", uflow, 1);

    // directed: enable dropped mid-word
    do_reset();
    chk(uflow == 1'b0, "R8 cleared by reset", uflow, 0);
    div = 8'd2; p = bitper(div);
    put(8'h00); put(8'h5A);
    @(negedge clk); en = 1'b1;
    hi = 1'b0;
    for (int t = 0; t < 40 * p; t++) begin
      @(negedge clk);
      if (!txd) begin hi = 1'b1; break; end
    end
    chk(hi, "R3 word starts", hi, 1);
    repeat (p + 1) @(negedge clk);
    chk(txd == 1'b0, "R3 zero data bit", txd, 0);
    en = 1'b0;
    @(negedge clk);
    chk(txd == 1'b1, "R7 line high after disable", txd, 1);
    hi = 1'b1;
    repeat (20 * p) begin @(negedge clk); hi &= txd; end
    chk(hi, "R7 line stays high", hi, 1);
    chk(hempty == 1'b0, "R7 no pop while disabled", hempty, 0);

    // random runs
    for (int r = 0; r < 6; r++) begin
      int n;
      do_reset();
      div = 8'($urandom % 4); p = bitper(div);
      n = 1 + ($urandom % 8);
      q.delete();
      for (int i = 0; i < n; i++) begin
        q.push_back(8'($urandom));
        put(q[i]);
      end
      chk(full == (n == 8), "R5 full after random fill", full, n == 8);
      @(negedge clk); en = 1'b1;
      for (int i = 0; i < n; i++) rx_byte(q[i], i != 0, i == n - 1, p);
      repeat (p + 1) @(negedge clk);
      chk(busy == 1'b0, "R9 idle after random run", busy, 0);
      chk(uflow == 1'b0, "R8 no underflow before next sync", uflow, 0);
      en = 1'b0;
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule